// File: doc/BRIEF.md
# Paddle Potentiometer Line Emulator

This block stands in for two analog paddle potentiometers attached to a host that reads position as a charge time. The host periodically discharges its sense line and then times how long each potentiometer line takes to rise again. The block watches the sensed line. When it sees the discharge edge, it records a timestamp from its own free-running counter and holds both potentiometer lines low. Each line is then let go after a delay that grows linearly with an 8-bit position value for that channel.

Each release is scheduled as an absolute counter value. That value is the captured timestamp plus a fixed base of 4096 clocks plus 8 clocks per position step. Both channels are therefore timed from the host's own discharge event, not from the block's internal phase. The outputs are pull-low enables: a 1 means the block drives the line low, and a 0 lets it rise. The capture strobe and the captured count are also brought out so that a surrounding controller can track the host's sampling rhythm.

Top module: `pot_line_emu`

## Requirements
- R1: Out of reset, both pull enables are 0, the capture strobe is 0 and the captured count is 0.
- R2: Each high-to-low transition of the sensed line causes exactly one capture, however long the line stays low. The capture raises the strobe for one cycle and asserts both pull enables in that same cycle. A rising transition captures nothing.
- R3: A pull enable asserted by a capture stays asserted for exactly 4096 + 8*P clock cycles, where P is the channel's position value read as an unsigned 8-bit number.
- R4: The extreme positions 0, 4 and 255 give low times of 4096, 4128 and 6136 cycles.
- R5: Two channels with equal positions release in the same cycle.
- R6: A position value that changes after a capture does not alter the release already scheduled by that capture.
- R7: A capture that arrives while releases are pending re-arms both channels from the new timestamp. This holds even when it lands in the very cycle of a release, and the line then stays low without a gap.
- R8: The captured count is a 16-bit counter that advances by one every clock. Two captures spaced K clocks apart report counts that differ by K modulo 65536.
- R9: A release target computed past 65535 wraps modulo 65536, and the low time is still 4096 + 8*P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pot_sense_i | input | 1 | Sensed potentiometer line level from the host side (asynchronous) |
| pos_a_i | input | 8 | Position value for channel A |
| pos_b_i | input | 8 | Position value for channel B |
| pull_a_o | output | 1 | 1 = drive channel A line low |
| pull_b_o | output | 1 | 1 = drive channel B line low |
| cap_stb_o | output | 1 | One-cycle pulse on each captured discharge edge |
| cap_cnt_o | output | 16 | Counter value taken at the last capture |

## Verification
Two events can fall in the same cycle: a capture that re-arms a channel, and that channel's own release match. The bench drops the sensed line a second time exactly 4096 cycles after the first, with channel A at position 0. Because both edges pass through the same synchronizer latency, the second capture lands on A's release cycle. The check is that A never goes high: its low time must come out as 8192 cycles. Channel B at position 10 must show 4096 + 4096 + 80 cycles. A second coincidence, two equal-position channels releasing together, is judged by equal low times measured from the shared capture.

// File: rtl/pot_emu_pkg.sv
package pot_emu_pkg;
  // Default geometry shared by the emulator and its submodules
  localparam int unsigned DEF_CNT_W     = 16;
  localparam int unsigned DEF_POS_W     = 8;
  localparam int unsigned DEF_BASE_OFS  = 4096;
  localparam int unsigned DEF_POS_SHIFT = 3;
  localparam int unsigned DEF_SYNC_N    = 2;
  localparam int unsigned NUM_CH        = 2;

  typedef enum logic [0:0] {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/pot_rst_sync.sv
module pot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/pot_fall_detect.sv
module pot_fall_detect #(
  parameter int unsigned SYNC_N = pot_emu_pkg::DEF_SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_i,
  output logic fall_o
);
  localparam int unsigned CHAIN_W = SYNC_N + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], sense_i};
  end

  // Idle level of the line is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];
endmodule

// File: rtl/pot_timebase.sv
module pot_timebase #(
  parameter int unsigned CNT_W = pot_emu_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pot_chan_sched.sv
module pot_chan_sched #(
  parameter int unsigned CNT_W     = pot_emu_pkg::DEF_CNT_W,
  parameter int unsigned POS_W     = pot_emu_pkg::DEF_POS_W,
  parameter int unsigned BASE_OFS  = pot_emu_pkg::DEF_BASE_OFS,
  parameter int unsigned POS_SHIFT = pot_emu_pkg::DEF_POS_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             pull_o,
  output logic [CNT_W-1:0] tgt_o
);
  localparam int unsigned     PAD_W  = CNT_W - POS_W;
  localparam logic [CNT_W-1:0] BASE_C = CNT_W'(BASE_OFS);

  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic             tgt_en;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] scaled;
  logic             hit;

  always_comb begin
    scaled = {{PAD_W{1'b0}}, pos_i} << POS_SHIFT;
    hit    = pend_q && (cnt_i == tgt_q);
    tgt_en = arm_i;
    tgt_d  = cnt_i + BASE_C + scaled;
    pend_d = pend_q;
    // A fresh capture wins over a release falling in the same cycle
    if (arm_i) begin
      pend_d = 1'b1;
    end else if (hit) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pull_o = pend_q;
  assign tgt_o  = tgt_q;
endmodule

// File: rtl/pot_line_emu.sv
module pot_line_emu #(
  parameter int unsigned CNT_W     = pot_emu_pkg::DEF_CNT_W,
  parameter int unsigned POS_W     = pot_emu_pkg::DEF_POS_W,
  parameter int unsigned BASE_OFS  = pot_emu_pkg::DEF_BASE_OFS,
  parameter int unsigned POS_SHIFT = pot_emu_pkg::DEF_POS_SHIFT,
  parameter int unsigned SYNC_N    = pot_emu_pkg::DEF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pot_sense_i,
  input  logic [POS_W-1:0] pos_a_i,
  input  logic [POS_W-1:0] pos_b_i,
  output logic             pull_a_o,
  output logic             pull_b_o,
  output logic             cap_stb_o,
  output logic [CNT_W-1:0] cap_cnt_o
);
  localparam int unsigned NCH = pot_emu_pkg::NUM_CH;

  logic             rst_sn;
  logic             cap_fire;
  logic [CNT_W-1:0] cnt_q;
  logic [POS_W-1:0] pos_arr  [NCH];
  logic             pull_arr [NCH];
  logic [CNT_W-1:0] tgt_arr  [NCH];
  logic [CNT_W-1:0] tgt_a, tgt_b;

  logic [CNT_W-1:0] cap_cnt_q, cap_cnt_d;
  logic             cap_stb_q, cap_stb_d;

  pot_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pot_fall_detect #(.SYNC_N(SYNC_N)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sn),
    .sense_i (pot_sense_i),
    .fall_o  (cap_fire)
  );

  pot_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk   (clk),
    .rst_n (rst_sn),
    .cnt_o (cnt_q)
  );

  assign pos_arr[pot_emu_pkg::CH_A] = pos_a_i;
  assign pos_arr[pot_emu_pkg::CH_B] = pos_b_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pot_chan_sched #(
      .CNT_W     (CNT_W),
      .POS_W     (POS_W),
      .BASE_OFS  (BASE_OFS),
      .POS_SHIFT (POS_SHIFT)
    ) u_sched (
      .clk    (clk),
      .rst_n  (rst_sn),
      .arm_i  (cap_fire),
      .cnt_i  (cnt_q),
      .pos_i  (pos_arr[ch]),
      .pull_o (pull_arr[ch]),
      .tgt_o  (tgt_arr[ch])
    );
  end

  always_comb begin
    cap_stb_d = cap_fire;
    cap_cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cap_cnt_q <= '0;
    end else if (cap_fire) begin
      cap_cnt_q <= cap_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cap_stb_q <= 1'b0;
    end else begin
      cap_stb_q <= cap_stb_d;
    end
  end

  assign tgt_a     = tgt_arr[pot_emu_pkg::CH_A];
  assign tgt_b     = tgt_arr[pot_emu_pkg::CH_B];
  assign pull_a_o  = pull_arr[pot_emu_pkg::CH_A];
  assign pull_b_o  = pull_arr[pot_emu_pkg::CH_B];
  assign cap_stb_o = cap_stb_q;
  assign cap_cnt_o = cap_cnt_q;
endmodule

// File: rtl/pot_line_emu_chk.sv
module pot_line_emu_chk #(
  parameter int unsigned CNT_W = pot_emu_pkg::DEF_CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             arm,
  input logic             pull_a,
  input logic             pull_b,
  input logic             cap_stb,
  input logic [CNT_W-1:0] cap_cnt,
  input logic [CNT_W-1:0] tgt_a,
  input logic [CNT_W-1:0] tgt_b
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  // R2
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> !cap_stb);

  // R2
  cap_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> (pull_a && pull_b));

  // R2
  rise_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_a) |-> cap_stb);

  // R2
  rise_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_b) |-> cap_stb);

  // R3
  fall_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(pull_a)) |-> (($past(cnt) == $past(tgt_a)) && !$past(arm)));

  // R3
  fall_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(pull_b)) |-> (($past(cnt) == $past(tgt_b)) && !$past(arm)));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R8
  cap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cap_stb) |-> (cap_cnt == $past(cnt)));
endmodule

bind pot_line_emu pot_line_emu_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_sn),
  .cnt     (cnt_q),
  .arm     (cap_fire),
  .pull_a  (pull_a_o),
  .pull_b  (pull_b_o),
  .cap_stb (cap_stb_o),
  .cap_cnt (cap_cnt_o),
  .tgt_a   (tgt_a),
  .tgt_b   (tgt_b)
);

// File: tb/pot_line_emu_tb_top.sv
module pot_line_emu_tb_top;
  logic        clk;
  logic        rst_n;
  logic        sense;
  logic [7:0]  pos_a, pos_b;
  logic        pull_a, pull_b, cap_stb;
  logic [15:0] cap_cnt;

  int checks;
  int errors;
  bit done;

  pot_line_emu dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pot_sense_i (sense),
    .pos_a_i     (pos_a),
    .pos_b_i     (pos_b),
    .pull_a_o    (pull_a),
    .pull_b_o    (pull_b),
    .cap_stb_o   (cap_stb),
    .cap_cnt_o   (cap_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int low_time(input int p);
    return 4096 + 8 * p;
  endfunction

  // One discharge cycle; optional mid-cycle position change and second discharge
  task automatic run_cycle(input int pa, input int pb, input int hold,
                           input int chg_at, input int chg_val, input int rearm_at,
                           output int la, output int lb, output int nstb,
                           output int cap1, output int cap2,
                           output int kend, output int kc);
    int k;
    bit seen;
    pos_a = 8'(pa);
    pos_b = 8'(pb);
    la = 0; lb = 0; nstb = 0; cap1 = -1; cap2 = -1; kc = 0; seen = 0;
    @(negedge clk);
    sense = 1'b0;
    k = 0;
    while (k < 12000) begin
      @(negedge clk);
      k++;
      if (k == hold) sense = 1'b1;
      if (rearm_at > 0 && k == rearm_at) sense = 1'b0;
      if (rearm_at > 0 && k == rearm_at + 8) sense = 1'b1;
      if (k == chg_at) begin
        pos_a = 8'(chg_val);
        pos_b = 8'(chg_val);
      end
      if (cap_stb) begin
        nstb++;
        if (nstb == 1) cap1 = int'(cap_cnt);
        else cap2 = int'(cap_cnt);
        kc = k;
      end
      if (pull_a) la++;
      if (pull_b) lb++;
      if (pull_a || pull_b) seen = 1;
      if (seen && !pull_a && !pull_b && k > hold && (rearm_at == 0 || k > rearm_at + 8))
        break;
    end
    kend = k;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    sense = 1'b1;
    pos_a = '0;
    pos_b = '0;
    repeat (5) @(negedge clk);
    check(!pull_a && !pull_b, "R1 pulls in reset", int'(pull_a) + int'(pull_b), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!pull_a && !pull_b, "R1 pulls after reset", int'(pull_a) + int'(pull_b), 0);
    check(!cap_stb, "R1 strobe after reset", int'(cap_stb), 0);
    check(cap_cnt == 16'd0, "R1 count after reset", int'(cap_cnt), 0);
  endtask

  task automatic test_values(input int pa, input int pb);
    int la, lb, ns, c1, c2, ke, kc;
    run_cycle(pa, pb, 8, 0, 0, 0, la, lb, ns, c1, c2, ke, kc);
    check(ns == 1, "R2 one capture", ns, 1);
    check(la == low_time(pa), "R3 R4 channel A low time", la, low_time(pa));
    check(lb == low_time(pb), "R3 R4 channel B low time", lb, low_time(pb));
  endtask

  task automatic test_equal();
    int la, lb, ns, c1, c2, ke, kc;
    run_cycle(127, 127, 8, 0, 0, 0, la, lb, ns, c1, c2, ke, kc);
    check(la == lb, "R5 equal positions same release", la, lb);
    check(la == low_time(127), "R5 equal position low time", la, low_time(127));
  endtask

  task automatic test_change();
    int la, lb, ns, c1, c2, ke, kc;
    run_cycle(50, 60, 8, 100, 250, 0, la, lb, ns, c1, c2, ke, kc);
    check(la == low_time(50), "R6 A unaffected by late change", la, low_time(50));
    check(lb == low_time(60), "R6 B unaffected by late change", lb, low_time(60));
  endtask

  task automatic test_long_hold();
    int la, lb, ns, c1, c2, ke, kc;
    run_cycle(20, 30, 300, 0, 0, 0, la, lb, ns, c1, c2, ke, kc);
    check(ns == 1, "R2 long discharge one capture", ns, 1);
    check(la == low_time(20), "R3 low time with long discharge", la, low_time(20));
  endtask

  task automatic test_rearm_coincident();
    int la, lb, ns, c1, c2, ke, kc;
    // Second capture lands on channel A's release cycle
    run_cycle(0, 10, 8, 0, 0, 4096, la, lb, ns, c1, c2, ke, kc);
    check(ns == 2, "R7 two captures", ns, 2);
    check(la == 4096 + low_time(0), "R7 A held through coincident re-arm", la, 4096 + low_time(0));
    check(lb == 4096 + low_time(10), "R7 B re-armed", lb, 4096 + low_time(10));
    check(((c2 - c1) & 16'hFFFF) == 4096, "R8 capture spacing 4096", (c2 - c1) & 16'hFFFF, 4096);
  endtask

  task automatic test_rearm_early();
    int la, lb, ns, c1, c2, ke, kc;
    run_cycle(30, 200, 8, 0, 0, 1000, la, lb, ns, c1, c2, ke, kc);
    check(la == 1000 + low_time(30), "R7 A early re-arm", la, 1000 + low_time(30));
    check(lb == 1000 + low_time(200), "R7 B early re-arm", lb, 1000 + low_time(200));
    check(((c2 - c1) & 16'hFFFF) == 1000, "R8 capture spacing 1000", (c2 - c1) & 16'hFFFF, 1000);
  endtask

  task automatic test_wrap();
    int la, lb, ns, c1, c2, ke, kc;
    int now_cnt, wait_n;
    run_cycle(1, 2, 8, 0, 0, 0, la, lb, ns, c1, c2, ke, kc);
    // Counter at the end of the run, plus the 4 idle cycles
    now_cnt = (c1 + 1 + (ke - kc) + 4) & 16'hFFFF;
    wait_n = (63000 - now_cnt) & 16'hFFFF;
    repeat (wait_n) @(negedge clk);
    run_cycle(255, 100, 8, 0, 0, 0, la, lb, ns, c1, c2, ke, kc);
    check(c1 >= 61440, "R9 capture near counter top", c1, 63000);
    check(la == low_time(255), "R9 A low time across wrap", la, low_time(255));
    check(lb == low_time(100), "R9 B low time across wrap", lb, low_time(100));
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    checks = 0;
    errors = 0;
    done = 0;
    test_reset();
    test_values(4, 255);
    test_values(255, 4);
    test_values(0, 128);
    test_values(200, 17);
    test_equal();
    test_change();
    test_long_hold();
    test_rearm_coincident();
    test_rearm_early();
    test_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule